// File: doc/BRIEF.md
# Memory Channel Index Hashing Unit

This unit sits behind a DRAM address decoder. It takes three fields that the decoder has already pulled out of a request: the row, the channel and the bank. From them it builds a new channel index and a sub-partition ID. Hashing the channel index with row bits spreads strided access streams over all channels, so that they do not pile up on one.

A 2-bit mode input travels with each request and picks the remapping. The unit can pass the channel through unchanged. It can fold the low row bits into the channel with XOR. It can also apply a fixed polynomial interleaving matrix that is defined only for a 32-channel system. A mode that the configured channel count cannot support, or a result that lands outside the channel range, raises a sticky error flag. Only a synchronous reset clears that flag.

The output is a single register stage with a valid/ready handshake. A request is taken when both inValid and inReady are high, and its result shows up on the next cycle. The result holds steady for as long as the consumer keeps outReady low. The channel count and the number of sub-partitions per channel are parameters.

Top module: `mem_chan_hash`

## Requirements
- R1: Mode 0 (plain) and mode 3 (reserved custom slot) each output the incoming channel unchanged.
- R2: Mode 1, when NUM_CH is a power of two, outputs inChan XOR (inRow[4:0] AND (NUM_CH-1)).
- R3: Mode 2, when NUM_CH is 32, outputs a channel whose bit k is inChan[k] XOR the parity of a fixed set of row bits. For bit 4 the set is rows 2,4,5,8,9,10,11,12. For bit 3 it is rows 1,3,4,7,8,9,10,11. For bit 2 it is rows 0,2,3,6,7,8,9,10,14. For bit 1 it is rows 1,4,6,7,10,11,12,13,14. For bit 0 it is rows 0,3,5,6,9,10,11,12,13.
- R4: Mode 1 with a NUM_CH that is not a power of two outputs the incoming channel unchanged and sets errFlag.
- R5: Mode 2 with NUM_CH other than 32 outputs the incoming channel unchanged and sets errFlag.
- R6: Any accepted request whose resulting channel is NUM_CH or above sets errFlag.
- R7: outSub equals outChan * SUB_PER_CH + (inBank AND (SUB_PER_CH-1)), where inBank is the bank of the same request.
- R8: A request accepted on a clock edge appears with outValid high after that edge; inReady is high whenever outValid is low.
- R9: While outValid is high and outReady is low, inReady is low and outChan and outSub keep their values.
- R10: errFlag is sticky: once set, it stays set until a synchronous reset. Reset clears errFlag and outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Remap select: 0 plain, 1 XOR fold, 2 polynomial, 3 custom (plain) |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Unit can take a request |
| inRow | input | ROW_W (16) | Decoded row field |
| inChan | input | CH_W (5) | Decoded channel field |
| inBank | input | BANK_W (4) | Decoded bank field |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outChan | output | CH_W (5) | Remapped channel index |
| outSub | output | CH_W+log2(SUB_PER_CH) (6) | Sub-partition ID |
| errFlag | output | 1 | Sticky illegal-configuration / range error |

## Verification
The assertions expect the consumer to drop outReady only while a result is pending. They also expect inRow, inChan, inBank and mode to be stable during the cycle a request is taken, because several properties compare the registered result against the $past value of the inputs. The bench drives every input on the falling edge and holds it through the accepting edge. Its random inChan values cover the full 5-bit range, so the 24-channel instance meets both in-range and out-of-range channels, and all four modes are drawn. Directed cases add back-pressure, with a second request held at the input, and reset clearing a latched error.

// File: rtl/mem_chan_hash_pkg.sv
package mem_chan_hash_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'd0,
    MODE_XOR    = 2'd1,
    MODE_POLY   = 2'd2,
    MODE_CUSTOM = 2'd3
  } remapMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture the computed result into the output register
    logic flagErr;  // the accepted request is illegal or out of range
  } hashStrobe_t;

  // taps of the polynomial interleave matrix, one mask per channel bit
  function automatic logic [15:0] polyTaps(input int bitIdx);
    case (bitIdx)
      0:       polyTaps = 16'h3E69;
      1:       polyTaps = 16'h7CD2;
      2:       polyTaps = 16'h47CD;
      3:       polyTaps = 16'h0F9A;
      4:       polyTaps = 16'h1F34;
      default: polyTaps = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mem_chan_hash_dp.sv
module mem_chan_hash_dp
  import mem_chan_hash_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int SUB_PER_CH = 2,
  parameter int ROW_W      = 16,
  parameter int CH_W       = 5,
  parameter int BANK_W     = 4,
  localparam int SUB_W     = CH_W + $clog2(SUB_PER_CH)
) (
  input  logic              clk,
  input  logic [1:0]        mode,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [CH_W-1:0]   inChan,
  input  logic [BANK_W-1:0] inBank,
  input  hashStrobe_t       strobe,
  output logic              reqBad,
  output logic [CH_W-1:0]   outChan,
  output logic [SUB_W-1:0]  outSub
);

  localparam bit IS_POW2 = ((NUM_CH & (NUM_CH - 1)) == 0);
  localparam bit POLY_OK = (NUM_CH == 32) && (CH_W >= 5) && (ROW_W >= 15);
  localparam int PAD_W   = (ROW_W > 16) ? ROW_W : 16;
  localparam logic [CH_W-1:0] CH_MASK = CH_W'(NUM_CH - 1);
  localparam logic [BANK_W-1:0] BANK_MASK = BANK_W'(SUB_PER_CH - 1);

  logic [PAD_W-1:0] rowPad;
  logic [CH_W-1:0]  xorChan;
  logic [CH_W-1:0]  polyChan;
  logic [CH_W-1:0]  nextChan;
  logic [SUB_W-1:0] nextSub;
  logic             cfgBad;
  logic             outOfRange;

  assign rowPad  = PAD_W'(inRow);
  assign xorChan = inChan ^ (rowPad[CH_W-1:0] & CH_MASK);

  // one parity tree per channel bit; bits above the matrix pass through
  for (genvar k = 0; k < CH_W; k++) begin : g_poly
    if (k < 5) begin : g_tap
      assign polyChan[k] = inChan[k] ^ (^(rowPad & PAD_W'(polyTaps(k))));
    end else begin : g_thru
      assign polyChan[k] = inChan[k];
    end
  end

  always_comb begin
    nextChan = inChan;
    cfgBad   = 1'b0;
    unique case (remapMode_t'(mode))
      MODE_XOR: begin
        if (IS_POW2) nextChan = xorChan;
        else         cfgBad   = 1'b1;
      end
      MODE_POLY: begin
        if (POLY_OK) nextChan = polyChan;
        else         cfgBad   = 1'b1;
      end
      default: nextChan = inChan;
    endcase
  end

  assign outOfRange = 32'(nextChan) >= 32'(NUM_CH);
  assign reqBad     = cfgBad || outOfRange;
  assign nextSub    = SUB_W'(nextChan) * SUB_W'(SUB_PER_CH)
                    + SUB_W'(inBank & BANK_MASK);

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      outChan <= nextChan;
      outSub  <= nextSub;
    end
  end

endmodule

// File: rtl/mem_chan_hash_ctl.sv
module mem_chan_hash_ctl
  import mem_chan_hash_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        reqBad,
  output logic        inReady,
  output logic        outValid,
  output logic        errFlag,
  output hashStrobe_t strobe
);

  logic accept;

  assign inReady        = !outValid || outReady;
  assign accept         = inValid && inReady;
  assign strobe.load    = accept;
  assign strobe.flagErr = accept && reqBad;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (accept)        outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
      if (strobe.flagErr) errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/mem_chan_hash.sv
module mem_chan_hash
  import mem_chan_hash_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int SUB_PER_CH = 2,
  parameter int ROW_W      = 16,
  parameter int CH_W       = 5,
  parameter int BANK_W     = 4,
  localparam int SUB_W     = CH_W + $clog2(SUB_PER_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [CH_W-1:0]   inChan,
  input  logic [BANK_W-1:0] inBank,
  output logic              outValid,
  input  logic              outReady,
  output logic [CH_W-1:0]   outChan,
  output logic [SUB_W-1:0]  outSub,
  output logic              errFlag
);

  hashStrobe_t strobe;
  logic        reqBad;

  mem_chan_hash_ctl i_ctl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .reqBad   (reqBad),
    .inReady  (inReady),
    .outValid (outValid),
    .errFlag  (errFlag),
    .strobe   (strobe)
  );

  mem_chan_hash_dp #(
    .NUM_CH     (NUM_CH),
    .SUB_PER_CH (SUB_PER_CH),
    .ROW_W      (ROW_W),
    .CH_W       (CH_W),
    .BANK_W     (BANK_W)
  ) i_dp (
    .clk     (clk),
    .mode    (mode),
    .inRow   (inRow),
    .inChan  (inChan),
    .inBank  (inBank),
    .strobe  (strobe),
    .reqBad  (reqBad),
    .outChan (outChan),
    .outSub  (outSub)
  );

endmodule

// File: rtl/mem_chan_hash_chk.sv
module mem_chan_hash_chk #(
  parameter int NUM_CH     = 32,
  parameter int SUB_PER_CH = 2,
  parameter int ROW_W      = 16,
  parameter int CH_W       = 5,
  parameter int BANK_W     = 4,
  localparam int SUB_W     = CH_W + $clog2(SUB_PER_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              inValid,
  input logic              inReady,
  input logic [ROW_W-1:0]  inRow,
  input logic [CH_W-1:0]   inChan,
  input logic [BANK_W-1:0] inBank,
  input logic              outValid,
  input logic              outReady,
  input logic [CH_W-1:0]   outChan,
  input logic [SUB_W-1:0]  outSub,
  input logic              errFlag
);

  localparam bit IS_POW2 = ((NUM_CH & (NUM_CH - 1)) == 0);
  localparam logic [CH_W-1:0] CH_MASK = CH_W'(NUM_CH - 1);
  localparam logic [BANK_W-1:0] BANK_MASK = BANK_W'(SUB_PER_CH - 1);

  logic take;
  assign take = inValid && inReady;

  assert_plain_R1: assert property (@(posedge clk) disable iff (rst)
    take && (mode == 2'd0 || mode == 2'd3) |=> outChan == $past(inChan));

  if (IS_POW2) begin : g_pow2
    assert_xor_R2: assert property (@(posedge clk) disable iff (rst)
      take && mode == 2'd1 |=> outChan == ($past(inChan) ^ ($past(inRow[CH_W-1:0]) & CH_MASK)));
  end else begin : g_npow2
    assert_xor_gap_R4: assert property (@(posedge clk) disable iff (rst)
      take && mode == 2'd1 |=> errFlag && outChan == $past(inChan));
  end

  if (NUM_CH != 32) begin : g_nopoly
    assert_poly_cnt_R5: assert property (@(posedge clk) disable iff (rst)
      take && mode == 2'd2 |=> errFlag && outChan == $past(inChan));
  end

  assert_range_R6: assert property (@(posedge clk) disable iff (rst)
    outValid && (32'(outChan) >= 32'(NUM_CH)) |-> errFlag);

  assert_sub_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> outSub == (SUB_W'(outChan) * SUB_W'(SUB_PER_CH) + SUB_W'($past(inBank) & BANK_MASK)));

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> outValid);

  assert_idle_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> inReady);

  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outChan) && $stable(outSub));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

endmodule

bind mem_chan_hash mem_chan_hash_chk #(
  .NUM_CH     (NUM_CH),
  .SUB_PER_CH (SUB_PER_CH),
  .ROW_W      (ROW_W),
  .CH_W       (CH_W),
  .BANK_W     (BANK_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .inValid  (inValid),
  .inReady  (inReady),
  .inRow    (inRow),
  .inChan   (inChan),
  .inBank   (inBank),
  .outValid (outValid),
  .outReady (outReady),
  .outChan  (outChan),
  .outSub   (outSub),
  .errFlag  (errFlag)
);

// File: tb/test_mem_chan_hash.sv
`timescale 1ns/1ps
module test_mem_chan_hash;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        inValid = 1'b0;
  logic [15:0] inRow = '0;
  logic [4:0]  inChan = '0;
  logic [3:0]  inBank = '0;
  logic        outReady = 1'b1;

  logic       inReady, outValid, errFlag;
  logic [4:0] outChan;
  logic [5:0] outSub;
  logic       inReadyOdd, outValidOdd, errFlagOdd;
  logic [4:0] outChanOdd;
  logic [5:0] outSubOdd;

  int nChecks = 0;
  int nFails  = 0;
  logic errOddExp = 1'b0;

  always #2.5 clk = ~clk;

  // 32-channel instance
  mem_chan_hash i_mem_chan_hash (
    .clk(clk), .rst(rst), .mode(mode), .inValid(inValid), .inReady(inReady),
    .inRow(inRow), .inChan(inChan), .inBank(inBank), .outValid(outValid),
    .outReady(outReady), .outChan(outChan), .outSub(outSub), .errFlag(errFlag)
  );

  // 24-channel instance (not a power of two, not 32)
  mem_chan_hash #(.NUM_CH(24)) i_mem_chan_hash_odd (
    .clk(clk), .rst(rst), .mode(mode), .inValid(inValid), .inReady(inReadyOdd),
    .inRow(inRow), .inChan(inChan), .inBank(inBank), .outValid(outValidOdd),
    .outReady(outReady), .outChan(outChanOdd), .outSub(outSubOdd), .errFlag(errFlagOdd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] polyRef(input logic [15:0] r, input logic [4:0] c);
    logic [4:0] p;
    p[0] = c[0] ^ r[0] ^ r[3] ^ r[5] ^ r[6] ^ r[9] ^ r[10] ^ r[11] ^ r[12] ^ r[13];
    p[1] = c[1] ^ r[1] ^ r[4] ^ r[6] ^ r[7] ^ r[10] ^ r[11] ^ r[12] ^ r[13] ^ r[14];
    p[2] = c[2] ^ r[0] ^ r[2] ^ r[3] ^ r[6] ^ r[7] ^ r[8] ^ r[9] ^ r[10] ^ r[14];
    p[3] = c[3] ^ r[1] ^ r[3] ^ r[4] ^ r[7] ^ r[8] ^ r[9] ^ r[10] ^ r[11];
    p[4] = c[4] ^ r[2] ^ r[4] ^ r[5] ^ r[8] ^ r[9] ^ r[10] ^ r[11] ^ r[12];
    return p;
  endfunction

  function automatic bit isPow2(input int n);
    return (n & (n - 1)) == 0;
  endfunction

  function automatic logic [4:0] chanRef(input logic [1:0] m, input logic [15:0] r,
                                         input logic [4:0] c, input int n);
    case (m)
      2'd1:    return isPow2(n) ? (c ^ (r[4:0] & 5'(n - 1))) : c;
      2'd2:    return (n == 32) ? polyRef(r, c) : c;
      default: return c;
    endcase
  endfunction

  function automatic bit badRef(input logic [1:0] m, input logic [15:0] r,
                                input logic [4:0] c, input int n);
    return (m == 2'd1 && !isPow2(n)) || (m == 2'd2 && n != 32) ||
           (int'(chanRef(m, r, c, n)) >= n);
  endfunction

  function automatic string tagOf(input logic [1:0] m, input bit odd);
    case (m)
      2'd1:    return odd ? "R4" : "R2";
      2'd2:    return odd ? "R5" : "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    errOddExp = 1'b0;
  endtask

  // one request with outReady high, checked after the accepting edge
  task automatic xfer(input logic [1:0] m, input logic [15:0] r,
                      input logic [4:0] c, input logic [3:0] b);
    logic [4:0] eMain, eOdd;
    mode = m; inRow = r; inChan = c; inBank = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    eMain = chanRef(m, r, c, 32);
    eOdd  = chanRef(m, r, c, 24);
    if (badRef(m, r, c, 24)) errOddExp = 1'b1;
    check("R8 outValid", 32'(outValid), 32'd1);
    check(tagOf(m, 0), 32'(outChan), 32'(eMain));
    check("R7 sub", 32'(outSub), 32'(6'(eMain) * 6'd2 + 6'(b[0])));
    check({tagOf(m, 1), " odd"}, 32'(outChanOdd), 32'(eOdd));
    check("R7 sub odd", 32'(outSubOdd), 32'(6'(eOdd) * 6'd2 + 6'(b[0])));
    check("R6/R10 err odd", 32'(errFlagOdd), 32'(errOddExp));
    check("R10 err main", 32'(errFlag), 32'd0);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20180615));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state R10 / R8
    check("R10 reset outValid", 32'(outValid), 32'd0);
    check("R10 reset errFlag", 32'(errFlagOdd), 32'd0);
    check("R8 idle inReady", 32'(inReady), 32'd1);

    // directed corner cases
    xfer(2'd0, 16'hFFFF, 5'd7, 4'h3);      // R1 plain, in range on both
    xfer(2'd3, 16'h1234, 5'd19, 4'h2);     // R1 custom slot
    xfer(2'd1, 16'h001F, 5'd0, 4'h1);      // R2 all-ones fold; R4 on odd
    check("R10 sticky after R4", 32'(errFlagOdd), 32'd1);
    xfer(2'd0, 16'h0000, 5'd1, 4'h0);
    check("R10 still set", 32'(errFlagOdd), 32'd1);
    doReset();
    check("R10 cleared by reset", 32'(errFlagOdd), 32'd0);
    xfer(2'd0, 16'h0000, 5'd30, 4'h0);     // R6: 30 >= 24 on odd
    doReset();
    xfer(2'd2, 16'h0001, 5'd0, 4'h0);      // R3 single row bit 0; R5 on odd
    xfer(2'd2, 16'h4000, 5'd0, 4'h0);      // R3 row bit 14
    xfer(2'd2, 16'h7FFF, 5'd31, 4'hF);     // R3 all taps
    doReset();

    // back-pressure R9
    outReady = 1'b0;
    mode = 2'd0; inRow = 16'h0; inChan = 5'd9; inBank = 4'h1; inValid = 1'b1;
    @(negedge clk);
    check("R8 taken under stall", 32'(outValid), 32'd1);
    inChan = 5'd4; inBank = 4'h0;          // second request waits
    check("R9 inReady low", 32'(inReady), 32'd0);
    repeat (2) @(negedge clk);
    check("R9 hold chan", 32'(outChan), 32'd9);
    check("R9 hold sub", 32'(outSub), 32'd19);
    check("R9 still valid", 32'(outValid), 32'd1);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 next after release", 32'(outChan), 32'd4);
    check("R7 next sub", 32'(outSub), 32'd8);
    @(negedge clk);
    check("R8 drains", 32'(outValid), 32'd0);
    doReset();

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  m;
      logic [15:0] r;
      logic [4:0]  c;
      logic [3:0]  b;
      m = 2'($urandom_range(0, 3));
      r = 16'($urandom);
      c = 5'($urandom_range(0, 31));
      b = 4'($urandom);
      xfer(m, r, c, b);
      if (i % 50 == 49) doReset();
    end

    finishRun();
  end

endmodule